// File: doc/BRIEF.md
# Dual-Width Instruction Expansion Front End

This block sits between instruction fetch and decode in a core that runs two instruction sets: a full 32-bit set and a compact 16-bit set. Fetch always hands over whole 32-bit words and does not know which set is active. The block keeps track of the current execution mode and uses that mode alone to decide how to read each word.

In normal mode, each word goes straight through as one instruction. In narrow mode, each word holds two 16-bit instructions. The low half is expanded and issued first. The high half is held and issued on the next cycle, so a new word is requested at most every other cycle. Expansion does several things:
- It widens the 3-bit register fields into the 5-bit normal fields.
- It maps a two-operand move's 5-bit fields directly.
- It fills in the operands that implied-operand forms leave out.
- It joins a prefix's extra bits onto the immediate of the next narrow instruction.

Mode switches, narrow no-ops and prefixes are consumed inside the block and never reach decode. A flush from a taken branch clears all held state and loads a new mode.

Top module: `dwx_frontend`

## Requirements
- R1: In normal mode with no flush, a fetch word whose bits [31:26] are not 6'h3F is issued unchanged as one instruction on the cycle it is accepted.
- R2: In narrow mode, an accepted word is split into two halves. Bits [15:0] are expanded and issued in the accepting cycle. Bits [31:16] are held and issued in the next cycle in which out_ready_i is high. While a half is held, fetch_ready_o is low.
- R3: In normal mode, a word with bits [31:26] = 6'h3F switches the block to narrow mode from the next word on. In narrow mode, a half with opcode 7'h7F switches back to normal mode. Neither mode switch is issued, and a narrow mode switch also cancels any pending prefix.
- R4: A narrow half has this layout: opcode in [15:9], d in [8:6], a in [5:3], b in [2:0]. Opcodes 7'h01 to 7'h04 expand to {op[5:0], rd=d, rs=a, rt=b, 11'b0}. The normal layout is op [31:26], rd [25:21], rs [20:16], rt [15:11], imm [10:0], with 3-bit registers zero-extended.
- R5: A half with [15:10] = 6'b110000 is a move with rd in [9:5] and rs in [4:0]. It expands to normal op 6'h01 with those full 5-bit registers and rt = 0.
- R6: The half 16'h0000 (narrow no-op) is dropped. Nothing is issued for it and a pending prefix is kept.
- R7: Opcode 7'h06 expands to op 6'h01 with rd=d, rs=d, rt=a. Opcode 7'h07 expands to op 6'h08 with rd=d, rs=d, rt=0, imm=4.
- R8: Opcode 7'h05 expands to op 6'h08 (rd=d, rs=a, rt=0, imm). Opcode 7'h08 expands to op 6'h10 with the same fields. Without a prefix, the imm is b zero-extended, so at most 7.
- R9: Opcode 7'h7E is a prefix. Nothing is issued for it, and its bits [7:0] become imm[10:3] of the next narrow instruction that is neither a no-op nor a prefix. That instruction consumes the prefix, including across a word boundary.
- R10: Any other narrow opcode is issued as 32'h0 with out_illegal_o high. It also consumes a pending prefix.
- R11: A narrow mode switch in bits [15:0] discards bits [31:16]. The next word is read as a normal instruction.
- R12: After reset the block is in normal mode with no held half and no prefix. out_valid_o is low while fetch_valid_i is low.
- R13: While flush_i is high, nothing is issued or accepted. On the following cycle, no half is held, no prefix is pending, and the mode equals flush_mode_i (1 = narrow).
- R14: While out_ready_i is low, nothing is consumed. The held half, the pending prefix and the mode are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_word_i | input | 32 | Fetched instruction word |
| fetch_valid_i | input | 1 | Fetch word valid |
| fetch_ready_o | output | 1 | Block accepts the fetch word |
| flush_i | input | 1 | Taken-branch flush |
| flush_mode_i | input | 1 | Mode loaded on flush (1 = narrow) |
| out_instr_o | output | 32 | Full-width instruction to decode |
| out_valid_o | output | 1 | out_instr_o valid |
| out_illegal_o | output | 1 | Issued instruction came from an unmapped narrow opcode |
| out_ready_i | input | 1 | Decode accepts the instruction |

## Verification
The bench targets three groups of corner cases.

The first group is the ordering and ownership of the two halves. Issuing the high half first would reorder every pair. A mode switch in the low half that failed to discard the held high half would issue a stray instruction in normal mode.

The second group is the lifetime of a prefix. Clearing it on a no-op would lose the extension. Failing to clear it after use would widen the immediate of a later instruction. Surviving a flush or mode switch would corrupt code at the branch target.

The third group is stalls and flushes that land while a high half is held. A design that advanced under a stall would drop or repeat halves. One that kept the held half across a flush would issue an instruction from the wrong path.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int OP_W   = 6;
  localparam int NOP_W  = 7;
  localparam int REG_W  = 5;
  localparam int NREG_W = 3;
  localparam int EXT_W  = 8;
  localparam int IMM_W  = EXT_W + NREG_W;

  typedef enum logic [1:0] {K_ISSUE, K_DROP, K_MODE, K_PREFIX} half_kind_e;

  // narrow opcodes
  localparam logic [NOP_W-1:0] X_NOP    = 7'h00;
  localparam logic [NOP_W-1:0] X_ADD    = 7'h01;
  localparam logic [NOP_W-1:0] X_SUB    = 7'h02;
  localparam logic [NOP_W-1:0] X_AND    = 7'h03;
  localparam logic [NOP_W-1:0] X_OR     = 7'h04;
  localparam logic [NOP_W-1:0] X_ADDI   = 7'h05;
  localparam logic [NOP_W-1:0] X_ADD2   = 7'h06;
  localparam logic [NOP_W-1:0] X_INC4   = 7'h07;
  localparam logic [NOP_W-1:0] X_LOAD   = 7'h08;
  localparam logic [NOP_W-1:0] X_MOVE0  = 7'h60;
  localparam logic [NOP_W-1:0] X_MOVE1  = 7'h61;
  localparam logic [NOP_W-1:0] X_PREFIX = 7'h7E;
  localparam logic [NOP_W-1:0] X_MODE   = 7'h7F;

  // normal opcodes
  localparam logic [OP_W-1:0] N_ADD  = 6'h01;
  localparam logic [OP_W-1:0] N_ADDI = 6'h08;
  localparam logic [OP_W-1:0] N_LOAD = 6'h10;
  localparam logic [OP_W-1:0] N_MODE = 6'h3F;
endpackage

// File: rtl/dwx_expand.sv
module dwx_expand
  import dwx_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  logic              ext_valid_i,
  input  logic [EXT_W-1:0]  ext_i,
  output half_kind_e        kind_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              illegal_o
);
  localparam int PAD_W = REG_W - NREG_W;

  logic [NOP_W-1:0] op;
  logic [REG_W-1:0] rd, ra, rb;
  logic [IMM_W-1:0] imm;

  assign op  = half_i[HALF_W-1 -: NOP_W];
  assign rd  = {{PAD_W{1'b0}}, half_i[3*NREG_W-1 -: NREG_W]};
  assign ra  = {{PAD_W{1'b0}}, half_i[2*NREG_W-1 -: NREG_W]};
  assign rb  = {{PAD_W{1'b0}}, half_i[NREG_W-1:0]};
  assign imm = ext_valid_i ? {ext_i, half_i[NREG_W-1:0]}
                           : {{EXT_W{1'b0}}, half_i[NREG_W-1:0]};

  always_comb begin
    kind_o    = K_ISSUE;
    illegal_o = 1'b0;
    instr_o   = '0;
    case (op)
      X_NOP:    kind_o = K_DROP;
      X_MODE:   kind_o = K_MODE;
      X_PREFIX: kind_o = K_PREFIX;
      X_ADD, X_SUB, X_AND, X_OR:
        instr_o = {op[OP_W-1:0], rd, ra, rb, {IMM_W{1'b0}}};
      X_ADDI:   instr_o = {N_ADDI, rd, ra, {REG_W{1'b0}}, imm};
      X_LOAD:   instr_o = {N_LOAD, rd, ra, {REG_W{1'b0}}, imm};
      X_ADD2:   instr_o = {N_ADD, rd, rd, ra, {IMM_W{1'b0}}};
      X_INC4:   instr_o = {N_ADDI, rd, rd, {REG_W{1'b0}}, IMM_W'(4)};
      X_MOVE0, X_MOVE1:
        instr_o = {N_ADD, half_i[2*REG_W-1 -: REG_W], half_i[REG_W-1:0],
                   {REG_W{1'b0}}, {IMM_W{1'b0}}};
      default:  illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dwx_half_buf.sv
module dwx_half_buf #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/dwx_prefix_reg.sv
module dwx_prefix_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [W-1:0] bits_i,
  output logic         valid_o,
  output logic [W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bits_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      bits_o  <= bits_i;
    end
  end
endmodule

// File: rtl/dwx_frontend.sv
module dwx_frontend
  import dwx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic              flush_i,
  input  logic              flush_mode_i,
  output logic [WORD_W-1:0] out_instr_o,
  output logic              out_valid_o,
  output logic              out_illegal_o,
  input  logic              out_ready_i
);
  logic              mode_q;
  logic              hold_valid;
  logic [HALF_W-1:0] hold_half;
  logic              ext_valid;
  logic [EXT_W-1:0]  ext_bits;
  logic [HALF_W-1:0] narrow_src;
  half_kind_e        kind;
  logic [WORD_W-1:0] exp_instr;
  logic              exp_illegal;
  logic              norm_path, norm_mc, item, adv;
  logic              hold_load, hold_clr, ext_set, ext_clr;

  assign narrow_src = hold_valid ? hold_half : fetch_word_i[HALF_W-1:0];

  dwx_expand u_expand (
    .half_i      (narrow_src),
    .ext_valid_i (ext_valid),
    .ext_i       (ext_bits),
    .kind_o      (kind),
    .instr_o     (exp_instr),
    .illegal_o   (exp_illegal)
  );

  assign norm_path = !mode_q && !hold_valid;
  assign norm_mc   = fetch_word_i[WORD_W-1 -: OP_W] == N_MODE;
  assign item      = hold_valid || fetch_valid_i;
  assign adv       = item && out_ready_i && !flush_i;

  assign fetch_ready_o = out_ready_i && !flush_i && !hold_valid;
  assign out_valid_o   = item && !flush_i && (norm_path ? !norm_mc : (kind == K_ISSUE));
  assign out_instr_o   = norm_path ? fetch_word_i : exp_instr;
  assign out_illegal_o = out_valid_o && !norm_path && exp_illegal;

  assign hold_load = adv && mode_q && !hold_valid && (kind != K_MODE);
  assign hold_clr  = flush_i || (adv && hold_valid);
  assign ext_set   = adv && !norm_path && (kind == K_PREFIX);
  assign ext_clr   = flush_i || (adv && !norm_path && (kind == K_ISSUE || kind == K_MODE));

  dwx_half_buf #(.W(HALF_W)) u_half_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hold_clr),
    .load_i  (hold_load),
    .data_i  (fetch_word_i[WORD_W-1:HALF_W]),
    .valid_o (hold_valid),
    .data_o  (hold_half)
  );

  dwx_prefix_reg #(.W(EXT_W)) u_prefix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ext_clr),
    .set_i   (ext_set),
    .bits_i  (narrow_src[EXT_W-1:0]),
    .valid_o (ext_valid),
    .bits_o  (ext_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mode_q <= 1'b0;
    else if (flush_i)                          mode_q <= flush_mode_i;
    else if (adv && norm_path && norm_mc)      mode_q <= 1'b1;
    else if (adv && !norm_path && kind == K_MODE) mode_q <= 1'b0;
  end

  p_hold_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_ready_o && mode_q && kind != K_MODE) |=> hold_valid);
  p_hold_drain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid && out_ready_i && !flush_i) |=> !hold_valid);
  p_enter_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_ready_o && !mode_q && norm_mc) |=> mode_q);
  p_low_mode_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && fetch_ready_o && mode_q && kind == K_MODE) |=> (!mode_q && !hold_valid));
  p_illegal_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_illegal_o |-> (out_valid_o && out_instr_o == '0));
  p_flush_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!hold_valid && !ext_valid && mode_q == $past(flush_mode_i)));
  p_stall_keep_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_ready_i && !flush_i) |=> ($stable(hold_valid) && $stable(hold_half)
                                   && $stable(ext_valid) && $stable(ext_bits) && $stable(mode_q)));
endmodule

// File: tb/dwx_frontend_tb_top.sv
`timescale 1ns/1ps
module dwx_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_word = '0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic        flush = 1'b0;
  logic        flush_mode = 1'b0;
  logic [31:0] out_instr;
  logic        out_valid, out_illegal;
  logic        out_ready = 1'b1;

  always #2.5 clk = ~clk;

  dwx_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_word_i(fetch_word), .fetch_valid_i(fetch_valid), .fetch_ready_o(fetch_ready),
    .flush_i(flush), .flush_mode_i(flush_mode),
    .out_instr_o(out_instr), .out_valid_o(out_valid), .out_illegal_o(out_illegal),
    .out_ready_i(out_ready)
  );

  typedef struct { logic [31:0] instr; logic ill; string tag; } exp_t;
  exp_t  sb_q[$];
  int    checks = 0, errors = 0;
  string tag_ovr = "";
  bit    stall_en = 0;
  bit    done = 0;

  // reference model state
  bit       m_mode = 0;
  bit       m_ext_v = 0;
  bit [7:0] m_ext = '0;

  task automatic push(input logic [31:0] i, input logic il, input string t);
    exp_t e;
    e.instr = i; e.ill = il; e.tag = (tag_ovr != "") ? tag_ovr : t;
    sb_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic model_half(input logic [15:0] h, output bit mc);
    logic [6:0]  op;
    logic [4:0]  d, a, b;
    logic [10:0] imm;
    string       t;
    op = h[15:9]; d = {2'b0, h[8:6]}; a = {2'b0, h[5:3]}; b = {2'b0, h[2:0]};
    imm = m_ext_v ? {m_ext, h[2:0]} : {8'b0, h[2:0]};
    t = m_ext_v ? "R9" : "R8";
    mc = 0;
    if (op == 7'h00) return;
    if (op == 7'h7F) begin m_mode = 0; m_ext_v = 0; mc = 1; return; end
    if (op == 7'h7E) begin m_ext_v = 1; m_ext = h[7:0]; return; end
    case (op)
      7'h01, 7'h02, 7'h03, 7'h04: push({op[5:0], d, a, b, 11'b0}, 0, "R4");
      7'h05: push({6'h08, d, a, 5'b0, imm}, 0, t);
      7'h08: push({6'h10, d, a, 5'b0, imm}, 0, t);
      7'h06: push({6'h01, d, d, a, 11'b0}, 0, "R7");
      7'h07: push({6'h08, d, d, 5'b0, 11'd4}, 0, "R7");
      7'h60, 7'h61: push({6'h01, h[9:5], h[4:0], 5'b0, 11'b0}, 0, "R5");
      default: push(32'h0, 1, "R10");
    endcase
    m_ext_v = 0;
  endtask

  task automatic model_word(input logic [31:0] w, output bit low_mc);
    bit mc2;
    low_mc = 0;
    if (!m_mode) begin
      if (w[31:26] == 6'h3F) m_mode = 1;
      else push(w, 0, "R1");
    end else begin
      model_half(w[15:0], low_mc);
      if (!low_mc) model_half(w[31:16], mc2);
    end
  endtask

  task automatic handshake(input logic [31:0] w);
    bit r;
    fetch_word = w; fetch_valid = 1'b1;
    forever begin
      @(negedge clk); r = fetch_ready;
      @(posedge clk); #1;
      if (r) break;
    end
    fetch_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    bit was_narrow, low_mc;
    was_narrow = m_mode;
    model_word(w, low_mc);
    handshake(w);
    if (was_narrow && !low_mc) begin
      @(negedge clk);
      check(fetch_ready == 1'b0, "R2 ready while half held", {31'b0, fetch_ready}, 32'h0);
      @(posedge clk); #1;
    end
    tag_ovr = "";
  endtask

  task automatic do_flush(input bit m);
    flush = 1'b1; flush_mode = m;
    @(negedge clk);
    check(out_valid == 1'b0, "R13 no issue during flush", {31'b0, out_valid}, 32'h0);
    @(posedge clk); #1;
    flush = 1'b0;
    m_mode = m; m_ext_v = 0;
  endtask

  // low half issued at accept, then flush while high half is held
  task automatic send_then_flush(input logic [31:0] w, input bit m);
    bit mc;
    model_half(w[15:0], mc);
    handshake(w);
    do_flush(m);
    tag_ovr = "";
  endtask

  function automatic logic [15:0] nh(input logic [6:0] op, input logic [2:0] d,
                                     input logic [2:0] a, input logic [2:0] b);
    return {op, d, a, b};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected issue actual=%h expected=none", out_instr);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (out_instr !== e.instr || out_illegal !== e.ill) begin
          errors++;
          $display("FAIL %s actual=%h/%b expected=%h/%b", e.tag, out_instr, out_illegal, e.instr, e.ill);
        end
      end
    end
  end

  // output backpressure
  initial forever begin
    @(posedge clk); #1;
    if (stall_en) out_ready = ($urandom % 3) != 0;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R14 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12 reset valid", {31'b0, out_valid}, 32'h0);
    check(fetch_ready == 1'b1, "R12 reset ready", {31'b0, fetch_ready}, 32'h1);
    @(posedge clk); #1;

    // R1 normal pass-through
    send_word(32'h0421_8000);
    send_word(32'hFBFF_FFFF);
    send_word(32'h1234_5678);
    // R3 enter narrow
    send_word(32'hFC00_0000);
    tag_ovr = "R3";
    send_word({nh(7'h02, 3'd1, 3'd2, 3'd3), nh(7'h01, 3'd7, 3'd6, 3'd5)});
    send_word({nh(7'h04, 3'd0, 3'd7, 3'd1), nh(7'h03, 3'd4, 3'd5, 3'd6)});
    send_word({7'h61, 9'h1F3, 7'h60, 9'h0A5});                       // R5 moves
    tag_ovr = "R6";
    send_word({16'h0000, nh(7'h01, 3'd3, 3'd3, 3'd3)});               // R6 nop pad
    send_word({nh(7'h07, 3'd5, 3'd0, 3'd0), nh(7'h06, 3'd2, 3'd4, 3'd0)}); // R7
    send_word({nh(7'h08, 3'd1, 3'd2, 3'd0), nh(7'h05, 3'd3, 3'd4, 3'd7)}); // R8 max 7
    send_word({nh(7'h05, 3'd6, 3'd1, 3'd5), 7'h7E, 9'h0A5});          // R9 same word
    send_word({16'h0000, 7'h7E, 9'h13C});                             // R9 prefix survives nop
    send_word({nh(7'h05, 3'd1, 3'd1, 3'd1), nh(7'h08, 3'd2, 3'd3, 3'd4)}); // consumes, then plain
    send_word({7'h7E, 9'h0FF, nh(7'h01, 3'd1, 3'd1, 3'd1)});          // prefix in high half
    send_word({nh(7'h08, 3'd1, 3'd1, 3'd1), nh(7'h05, 3'd0, 3'd0, 3'd2)}); // R9 across words
    send_word({nh(7'h05, 3'd1, 3'd1, 3'd1), 7'h7E, 9'h055});
    send_word({nh(7'h09, 3'd1, 3'd1, 3'd1), nh(7'h3A, 3'd0, 3'd0, 3'd0)}); // R10 illegal
    // R11 low-half mode switch discards high half
    send_word({nh(7'h01, 3'd7, 3'd7, 3'd7), 7'h7F, 9'h000});
    tag_ovr = "R11";
    send_word(32'hABCD_0123);
    // R3 high-half mode switch
    send_word(32'hFC00_0000);
    send_word({7'h7F, 9'h000, nh(7'h02, 3'd2, 3'd2, 3'd2)});
    tag_ovr = "R3";
    send_word(32'h0000_0001);
    // R13 flush clears prefix
    send_word(32'hFC00_0000);
    send_word({7'h7E, 9'h0FF, nh(7'h01, 3'd1, 3'd2, 3'd3)});
    do_flush(1'b1);
    tag_ovr = "R13";
    send_word({nh(7'h01, 3'd0, 3'd0, 3'd0), nh(7'h05, 3'd4, 3'd4, 3'd6)});
    // R13 flush drops held half and loads normal mode
    send_then_flush({nh(7'h01, 3'd5, 3'd5, 3'd5), nh(7'h02, 3'd6, 3'd6, 3'd6)}, 1'b0);
    tag_ovr = "R13";
    send_word(32'h5555_AAAA);

    // R14 backpressure with mixed random traffic
    stall_en = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 17 == 0) w = m_mode ? {w[31:16], 7'h7F, w[8:0]} : {6'h3F, w[25:0]};
      tag_ovr = "R14";
      send_word(w);
    end
    stall_en = 0;
    out_ready = 1'b1;
    repeat (10) @(posedge clk);
    check(sb_q.size() == 0, "R2 all halves issued", sb_q.size(), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule